// File: doc/BRIEF.md
# Multiplexed Asynchronous Parallel Memory Port

This block sits between an internal 32-bit word requester and slow asynchronous external memory. Both the address and the data travel over the same sixteen shared lines. The two kinds of value use the lines at different times, and an address-latch strobe marks the cycles that carry an address. A requester asks for one 32-bit read or write with a single-cycle request while the port is not busy, much as a DMA channel would. The port then runs several narrow external transfers and reports completion with a one-cycle pulse.

The port has two bus widths, chosen per request. In the narrow mode each transfer moves one byte and the external address is 24 bits wide, so it is sent in two address cycles: the high part first, then the low part. In the wide mode each transfer moves a halfword, and a 16-bit address needs only one address cycle. A word is built from four bytes or from two halfwords in little-endian order. The read or write strobe stays low for a programmable number of clock cycles, and values below the minimum of two are raised to two.

Top module: `mapp_port`

## Requirements
- R1: After reset, busy and done are 0, req_ready is 1, rd_n and wr_n are 1, ale is 0 and ad_oe is 0.
- R2: With cfg_wide=0 a request makes 4 transfers. Transfer k (k=0..3) uses address A=req_addr+k (24-bit wrap). It has two cycles with ale=1: the first drives ad_out={8'h00,A[23:16]} and the second drives ad_out=A[15:0]. Its data phase follows.
- R3: With cfg_wide=1 a request makes 2 transfers. Transfer k (k=0..1) has one cycle with ale=1 that drives ad_out=req_addr[15:0]+k (16-bit wrap). Its data phase follows.
- R4: Reads are packed little-endian, and ad_in is sampled in the last cycle of each data phase. In narrow mode transfer k supplies ad_in[7:0] to rdata[8k+7:8k], and ad_in[15:8] is ignored. In wide mode transfer k supplies ad_in[15:0] to rdata[16k+15:16k].
- R5: Writes are unpacked the same way. During the data phase of transfer k, narrow mode drives ad_out={8'h00, byte k of req_wdata} and wide mode drives halfword k. ad_oe is 1 for the whole write data phase.
- R6: rd_n (read) or wr_n (write) is low for the entire data phase of every transfer and is never low in any other cycle. The two strobes are never low together, and neither is low while ale=1. ad_oe is 0 whenever rd_n is low.
- R7: Every data phase lasts L = max(cfg_len, 2) cycles, where cfg_len is a 5-bit count (0..31).
- R8: busy is 1 from the cycle after a request is accepted. It stays 1 for 4*(2+L) cycles in narrow mode and 2*(1+L) cycles in wide mode. req_ready equals !busy. A request held while busy waits and is accepted only in the first cycle after busy falls.
- R9: done is high for exactly one cycle, the first cycle after busy falls. In that cycle rdata holds the packed read word, or zero after a write.
- R10: Mode, length, address and write data are captured when the request is accepted. Changes to those inputs during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Word request present |
| req_ready | output | 1 | Request accepted in this cycle if valid |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | 24 | External base address of the word |
| req_wdata | input | 32 | Word to write |
| cfg_wide | input | 1 | 0 = 8-bit data/24-bit address, 1 = 16-bit data/16-bit address |
| cfg_len | input | 5 | Data-phase length in cycles (minimum 2) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Packed read word, valid with done |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Value read back from the shared lines |
| ale | output | 1 | Address latch enable, high in address cycles |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The delicate coincidence is a completion and the acceptance of the next request landing in the same cycle: the done pulse of one word is also the single idle cycle in which a stalled request may enter. The bench holds req_valid high with a second, different request through the whole of a first transfer. It then checks three things: that all of the first word's address cycles precede the second's, that the second word's first ale cycle comes exactly one cycle after the done pulse, and that the total busy time equals the sum of both words. A separate test changes mode, length, address and data in the middle of a transfer and checks that the strobe lengths, address sequence and packed result follow the captured values.

// File: rtl/mapp_pkg.sv
`timescale 1ns/1ps
package mapp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR_HI = 2'd1,
        ST_ADDR_LO = 2'd2,
        ST_DATA    = 2'd3
    } mapp_state_e;
endpackage

// File: rtl/mapp_len_timer.sv
`timescale 1ns/1ps
// Counts the cycles of one data phase; flags its final cycle.
module mapp_len_timer #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        last = active && (cnt_q == len - LEN_W'(1));
        if (!active || last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: a data phase never ends after its first cycle
    assert_min_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_q == '0) |=> active);

    // R7: the count never passes the programmed length
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < len));
endmodule

// File: rtl/mapp_addr_gen.sv
`timescale 1ns/1ps
// Forms the address value placed on the shared lines in an address cycle.
module mapp_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int AD_W   = 16,
    parameter int BEAT_W = 2
) (
    input  logic              wide,
    input  logic              hi_phase,
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    output logic [AD_W-1:0]   ad_addr
);
    localparam int HI_W = ADDR_W - AD_W;

    logic [ADDR_W-1:0] cur;

    always_comb begin
        cur = base + ADDR_W'(beat);
        if (!wide && hi_phase) begin
            ad_addr = {{(AD_W - HI_W){1'b0}}, cur[ADDR_W-1:AD_W]};
        end else begin
            ad_addr = cur[AD_W-1:0];
        end
    end
endmodule

// File: rtl/mapp_lane_pack.sv
`timescale 1ns/1ps
// Little-endian packing of incoming lanes and lane selection for writes.
module mapp_lane_pack #(
    parameter int AD_W   = 16,
    parameter int WORD_W = 32,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              wide,
    input  logic [BEAT_W-1:0] beat,
    input  logic [AD_W-1:0]   din,
    input  logic [WORD_W-1:0] wdata,
    output logic [AD_W-1:0]   dout,
    output logic [WORD_W-1:0] acc
);
    localparam int NB    = AD_W / 2;
    localparam int NLANE = WORD_W / NB;
    localparam int NHALF = WORD_W / AD_W;
    localparam int HB_W  = $clog2(NHALF);

    logic [WORD_W-1:0] acc_d, acc_q;
    logic [NB-1:0]     wbyte   [NLANE];
    logic [AD_W-1:0]   whalf   [NHALF];
    logic [NB-1:0]     lane_nx [NLANE];

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam int HALF_IDX = i / 2;
        localparam int SUB      = i % 2;
        logic narrow_hit, wide_hit;
        assign wbyte[i]   = wdata[i*NB +: NB];
        assign narrow_hit = !wide && (beat == BEAT_W'(i));
        assign wide_hit   = wide && (beat == BEAT_W'(HALF_IDX));
        assign lane_nx[i] = clear                    ? '0 :
                            (capture && narrow_hit)  ? din[NB-1:0] :
                            (capture && wide_hit)    ? din[SUB*NB +: NB] :
                                                       acc_q[i*NB +: NB];
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign whalf[h] = wdata[h*AD_W +: AD_W];
    end

    always_comb begin
        for (int k = 0; k < NLANE; k++) begin
            acc_d[k*NB +: NB] = lane_nx[k];
        end
        if (wide) begin
            dout = whalf[beat[HB_W-1:0]];
        end else begin
            dout = {{(AD_W - NB){1'b0}}, wbyte[beat]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;

    // R4: a wide capture always targets an existing halfword lane
    assert_wide_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && wide) |-> (beat < BEAT_W'(NHALF)));

    // R4: a new request never clears in the same cycle as a capture
    assert_clear_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !capture);
endmodule

// File: rtl/mapp_port.sv
`timescale 1ns/1ps
// Word-level port onto a 16-line shared address/data asynchronous bus.
module mapp_port
    import mapp_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int AD_W    = 16,
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 5,
    parameter int MIN_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              cfg_wide,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [AD_W-1:0]   ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int NB           = AD_W / 2;
    localparam int NARROW_BEATS = WORD_W / NB;
    localparam int WIDE_BEATS   = WORD_W / AD_W;
    localparam int BEAT_W       = $clog2(NARROW_BEATS);

    typedef struct packed {
        mapp_state_e       st;
        logic [BEAT_W-1:0] beat;
        logic              wide;
        logic              write;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] wdata;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic            accept;
    logic            in_data;
    logic            in_addr;
    logic            data_last;
    logic            last_beat;
    logic            capture;
    logic [AD_W-1:0] addr_word;
    logic [AD_W-1:0] lane_out;

    assign in_data = (r_q.st == ST_DATA);
    assign in_addr = (r_q.st == ST_ADDR_HI) || (r_q.st == ST_ADDR_LO);
    assign accept  = req_valid && (r_q.st == ST_IDLE);
    assign capture = in_data && !r_q.write && data_last;

    mapp_len_timer #(.LEN_W(LEN_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_data),
        .len    (r_q.len),
        .last   (data_last)
    );

    mapp_addr_gen #(.ADDR_W(ADDR_W), .AD_W(AD_W), .BEAT_W(BEAT_W)) u_agen (
        .wide     (r_q.wide),
        .hi_phase (r_q.st == ST_ADDR_HI),
        .base     (r_q.base),
        .beat     (r_q.beat),
        .ad_addr  (addr_word)
    );

    mapp_lane_pack #(.AD_W(AD_W), .WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture),
        .wide    (r_q.wide),
        .beat    (r_q.beat),
        .din     (ad_in),
        .wdata   (r_q.wdata),
        .dout    (lane_out),
        .acc     (rdata)
    );

    always_comb begin
        last_beat = r_q.wide ? (r_q.beat == BEAT_W'(WIDE_BEATS - 1))
                             : (r_q.beat == BEAT_W'(NARROW_BEATS - 1));
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.wide  = cfg_wide;
                    r_d.write = req_write;
                    r_d.len   = (cfg_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cfg_len;
                    r_d.base  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.beat  = '0;
                    r_d.st    = cfg_wide ? ST_ADDR_LO : ST_ADDR_HI;
                end
            end
            ST_ADDR_HI: r_d.st = ST_ADDR_LO;
            ST_ADDR_LO: r_d.st = ST_DATA;
            ST_DATA: begin
                if (data_last) begin
                    if (last_beat) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.beat = r_q.beat + BEAT_W'(1);
                        r_d.st   = r_q.wide ? ST_ADDR_LO : ST_ADDR_HI;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != ST_IDLE);
        req_ready = !busy;
        done      = r_q.done;
        ale       = in_addr;
        rd_n      = !(in_data && !r_q.write);
        wr_n      = !(in_data && r_q.write);
        ad_oe     = in_addr || (in_data && r_q.write);
        if (in_addr) begin
            ad_out = addr_word;
        end else if (in_data && r_q.write) begin
            ad_out = lane_out;
        end else begin
            ad_out = '0;
        end
    end

    // R6: read and write strobes are mutually exclusive
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6: no strobe during an address cycle
    assert_ale_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    // R6: the lines are released while reading
    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R8: work starts only in response to a request
    assert_busy_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9: completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion follows a busy period
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: tb/tb_mapp_port.sv
`timescale 1ns/1ps
module tb_mapp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_ready, req_write;
    logic [23:0] req_addr;
    logic [31:0] req_wdata, rdata;
    logic        cfg_wide;
    logic [4:0]  cfg_len;
    logic        busy, done, ad_oe, ale, rd_n, wr_n;
    logic [15:0] ad_out, ad_in;

    always #5 clk = ~clk;

    mapp_port dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wide(cfg_wide), .cfg_len(cfg_len), .busy(busy), .done(done),
        .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    // external memory model: contents are a function of the latched address
    bit          tb_wide = 1'b0;
    logic [23:0] lat = '0;

    function automatic logic [7:0] nar_byte(logic [23:0] a);
        return a[7:0] ^ a[23:16] ^ 8'hC3;
    endfunction
    function automatic logic [15:0] wide_half(logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'h3C};
    endfunction

    assign ad_in = rd_n ? 16'h0000
                 : (tb_wide ? wide_half(lat[15:0]) : {8'hEE, nar_byte(lat)});

    // bus monitor
    logic [15:0] ale_log [16];
    int          ale_t   [16];
    logic [15:0] wlog    [8];
    int          runs    [8];
    int ale_n = 0, w_n = 0, r_n = 0, run = 0;
    int busy_cnt = 0, done_cnt = 0, done_t = 0, bus_bad = 0, cyc = 0;
    logic [31:0] done_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (done) begin
                if (done_cnt == 0) done_t = cyc;
                done_cnt++;
                done_data = rdata;
            end
            if (ale) begin
                lat = {lat[7:0], ad_out};
                if (ale_n < 16) begin
                    ale_log[ale_n] = ad_out;
                    ale_t[ale_n] = cyc;
                end
                ale_n++;
            end
            if (!rd_n && ad_oe) bus_bad++;
            if (!wr_n && !ad_oe) bus_bad++;
            if (!rd_n && !wr_n) bus_bad++;
            if (!wr_n && run == 0) begin
                if (w_n < 8) wlog[w_n] = ad_out;
                w_n++;
            end else if (!wr_n && w_n > 0 && w_n <= 8) begin
                if (ad_out !== wlog[w_n-1]) bus_bad++;
            end
            if (!rd_n || !wr_n) begin
                run++;
            end else if (run != 0) begin
                if (r_n < 8) runs[r_n] = run;
                r_n++;
                run = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        ale_n = 0; w_n = 0; r_n = 0; run = 0;
        busy_cnt = 0; done_cnt = 0; bus_bad = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // one word transfer with full checking of the bus trace
    task automatic do_xfer(input bit wr, input bit wide, input logic [23:0] a,
                           input logic [31:0] wd, input logic [4:0] len,
                           input bit disturb, input string tag);
        int leff, beats, apl, ale_bad, run_bad, w_bad;
        logic [31:0] exp;
        logic [23:0] ak;
        leff  = (len < 5'd2) ? 2 : int'(len);
        beats = wide ? 2 : 4;
        apl   = wide ? 1 : 2;
        @(negedge clk);
        clear_logs();
        tb_wide   = wide;
        req_valid = 1'b1; req_write = wr; cfg_wide = wide; cfg_len = len;
        req_addr  = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (disturb) begin
            cfg_wide = !wide; cfg_len = 5'd9; req_addr = ~a; req_wdata = ~wd;
        end
        while (done_cnt < 1) @(negedge clk);
        @(negedge clk);
        cfg_wide = wide; cfg_len = len;

        exp = '0;
        if (!wr) begin
            for (int k = 0; k < beats; k++) begin
                if (wide) exp[k*16 +: 16] = wide_half(a[15:0] + 16'(k));
                else      exp[k*8 +: 8]   = nar_byte(a + 24'(k));
            end
        end
        chk({tag, " R9 one done pulse"}, 32'(done_cnt), 32'd1);
        chk({tag, " R4 R9 rdata at done"}, done_data, exp);
        chk({tag, " R8 busy length"}, 32'(busy_cnt), 32'(beats * (apl + leff)));
        chk({tag, " R2 R3 address cycle count"}, 32'(ale_n), 32'(beats * apl));
        ale_bad = 0;
        for (int k = 0; k < beats; k++) begin
            ak = a + 24'(k);
            if (wide) begin
                if (ale_log[k] !== (a[15:0] + 16'(k))) ale_bad++;
            end else begin
                if (ale_log[2*k] !== {8'h00, ak[23:16]}) ale_bad++;
                if (ale_log[2*k+1] !== ak[15:0]) ale_bad++;
            end
        end
        chk({tag, " R2 R3 address values"}, 32'(ale_bad), 32'd0);
        chk({tag, " R6 strobe count"}, 32'(r_n), 32'(beats));
        run_bad = 0;
        for (int k = 0; k < beats; k++) if (runs[k] != leff) run_bad++;
        chk({tag, " R7 strobe length"}, 32'(run_bad), 32'd0);
        if (wr) begin
            chk({tag, " R5 write transfer count"}, 32'(w_n), 32'(beats));
            w_bad = 0;
            for (int k = 0; k < beats; k++) begin
                if (wide) begin
                    if (wlog[k] !== wd[k*16 +: 16]) w_bad++;
                end else begin
                    if (wlog[k] !== {8'h00, wd[k*8 +: 8]}) w_bad++;
                end
            end
            chk({tag, " R5 write lanes"}, 32'(w_bad), 32'd0);
        end
        chk({tag, " R6 bus discipline"}, 32'(bus_bad), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", 32'({busy, req_ready, rd_n, wr_n, ale, ad_oe, done}),
            32'(7'b0111000));
    endtask

    task automatic t_read_narrow();
        do_xfer(1'b0, 1'b0, 24'h12FFFE, 32'h0, 5'd3, 1'b0, "narrow read across carry");
    endtask

    task automatic t_read_wide();
        do_xfer(1'b0, 1'b1, 24'hABFFFF, 32'h0, 5'd4, 1'b0, "wide read with wrap");
    endtask

    task automatic t_write_narrow();
        do_xfer(1'b1, 1'b0, 24'h004410, 32'hDEADBEEF, 5'd2, 1'b0, "narrow write");
    endtask

    task automatic t_write_wide();
        do_xfer(1'b1, 1'b1, 24'h000100, 32'hCAFE1234, 5'd6, 1'b0, "wide write");
    endtask

    task automatic t_clamp_R7();
        do_xfer(1'b0, 1'b0, 24'h7F0010, 32'h0, 5'd0, 1'b0, "R7 length 0 clamped");
        do_xfer(1'b0, 1'b1, 24'h002222, 32'h0, 5'd1, 1'b0, "R7 length 1 clamped");
        do_xfer(1'b1, 1'b1, 24'h00F00F, 32'h600DF00D, 5'd31, 1'b0, "R7 length 31");
    endtask

    task automatic t_cfg_change_R10();
        do_xfer(1'b0, 1'b0, 24'h345678, 32'h0, 5'd3, 1'b1, "R10 inputs changed mid read");
        do_xfer(1'b1, 1'b1, 24'h00BEEF, 32'h89ABCDEF, 5'd2, 1'b1, "R10 inputs changed mid write");
    endtask

    // a second request held valid while the first runs
    task automatic t_stall_R8();
        int run_bad;
        logic [31:0] exp;
        @(negedge clk);
        clear_logs();
        tb_wide   = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; cfg_wide = 1'b1; cfg_len = 5'd2;
        req_addr  = 24'h001230; req_wdata = 32'h55AA0FF0;
        @(negedge clk);
        req_write = 1'b0; req_addr = 24'h00ABC0; cfg_len = 5'd3;
        chk("R8 ready low while busy", 32'(req_ready), 32'd0);
        while (done_cnt < 1) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt < 2) @(negedge clk);
        @(negedge clk);
        chk("R8 stalled address count", 32'(ale_n), 32'd4);
        chk("R8 stalled address order",
            {ale_log[0], ale_log[1]}, {16'h1230, 16'h1231});
        chk("R8 second request addresses",
            {ale_log[2], ale_log[3]}, {16'hABC0, 16'hABC1});
        chk("R8 R9 accept in done cycle", 32'(ale_t[2]), 32'(done_t + 1));
        run_bad = 0;
        if (runs[0] != 2 || runs[1] != 2 || runs[2] != 3 || runs[3] != 3) run_bad = 1;
        chk("R7 R8 per-request lengths", 32'(run_bad), 32'd0);
        chk("R5 first request write lanes", {wlog[1], wlog[0]}, 32'h55AA0FF0);
        exp = {wide_half(16'hABC1), wide_half(16'hABC0)};
        chk("R4 second request rdata", done_data, exp);
        chk("R8 combined busy length", 32'(busy_cnt), 32'd14);
        chk("R6 stall bus discipline", 32'(bus_bad), 32'd0);
    endtask

    initial begin
        req_valid = 1'b0; req_write = 1'b0; cfg_wide = 1'b0; cfg_len = 5'd2;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_narrow();
        t_read_wide();
        t_write_narrow();
        t_write_wide();
        t_clamp_R7();
        t_cfg_change_R10();
        t_stall_R8();
        t_reset();
        summary();
        $finish;
    end

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule